// File: doc/BRIEF.md
# Receive Descriptor Finisher with Overflow Drain

This block closes out a received frame into the receive buffer descriptor that the DMA side currently presents, and it disposes of frames that turn up while no descriptor is available. When a frame-done strobe arrives and the presented descriptor is marked ready, the block writes the descriptor word back. The frame's byte length goes into the upper half of the word, optionally padded by four bytes so that software sees room for a CRC that is not actually there. The ready flag is cleared, and the receive-buffer bit of a small interrupt-source register is raised.

When the descriptor is not ready, the block pops every waiting frame from the receive input, one per cycle, until the input reports empty. A frame-done strobe that arrives in that state counts as a discard and does not complete anything. Once the input is empty and at least one frame was discarded, the busy bit of the interrupt-source register is set. One interrupt line follows the masked sources. A separate event pulse is generated only when that line goes from inactive to active, so an event arriving while the line is already up produces no new pulse.

Top module: `rx_desc_finish`

## Requirements
- R1: After reset the interrupt-source bits, the interrupt line, the event pulse and the descriptor write strobe are all 0.
- R2: CRC padding is enabled after reset. A completion then writes frame length + 4 into descriptor bits 31:16.
- R3: When cfg_we loads cfg_crc_pad = 0, later completions write the frame length + 0. Loading 1 restores the +4 padding.
- R4: A completion (frame_done while desc_in bit 15 is 1) asserts desc_we for exactly one cycle, starting one clock after the strobe. desc_out then has bit 15 cleared and bits 14:0 copied from desc_in.
- R5: A completion sets int_src bit 0 (receive buffer) one clock after the strobe.
- R6: While desc_in bit 15 is 0 and rx_pending is 1, drop_pop is 1 in that same cycle. frame_done in that state produces no descriptor write.
- R7: After at least one discard (a drop_pop cycle or a frame_done with no ready descriptor), int_src bit 1 (busy) is set one clock after the first cycle in which rx_pending is 0.
- R8: irq_line is the registered OR of int_src AND irq_mask, where mask bit 0 covers receive-buffer and bit 1 covers busy. irq_event pulses for one cycle together with a 0-to-1 change of irq_line.
- R9: A busy or receive-buffer event that arrives while irq_line is already 1 produces no irq_event.
- R10: A 1 on a src_clr bit clears that int_src bit one clock later. A set in the same cycle overrides the clear.
- R11: The stored length wraps modulo 2^16. A length of 0xFFFE with padding is stored as 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the CRC-padding setting |
| cfg_crc_pad | input | 1 | New CRC-padding setting (1 = add four bytes) |
| frame_done | input | 1 | One-cycle strobe: a received frame has ended |
| frame_len | input | 16 | Byte length of the ended frame |
| desc_in | input | 32 | Currently presented descriptor word; bit 15 = ready |
| rx_pending | input | 1 | Receive input holds at least one frame |
| drop_pop | output | 1 | Discard one waiting frame this cycle |
| desc_we | output | 1 | Descriptor write-back strobe |
| desc_out | output | 32 | Descriptor word to write back |
| src_clr | input | 2 | Write-one-to-clear for interrupt-source bits |
| irq_mask | input | 2 | Interrupt enable per source (bit 0 rx buffer, bit 1 busy) |
| int_src | output | 2 | Interrupt-source bits (bit 0 rx buffer, bit 1 busy) |
| irq_line | output | 1 | Interrupt line |
| irq_event | output | 1 | One-cycle pulse when the line becomes active |

## Verification
drop_pop is combinational and is checked in the same cycle the inputs are driven. desc_we, desc_out, the receive-buffer bit, the line and the event all appear one clock after the stimulus edge. The busy bit, and the line change it causes, appear one clock after the first cycle with the receive input empty. Inputs change on the falling edge, and each result is sampled on the falling edge that follows the rising edge at which it is due. Every check therefore lands on the exact cycle the requirement names.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    localparam int DESC_W    = 32;
    localparam int LEN_W     = 16;
    localparam int LEN_LSB   = DESC_W - LEN_W;
    localparam int RDY_BIT   = 15;
    localparam int PAD_BYTES = 4;
    localparam int NSRC      = 2;
    localparam int SRC_RXB   = 0;
    localparam int SRC_BUSY  = 1;

    typedef logic [DESC_W-1:0] desc_t;
    typedef logic [LEN_W-1:0]  len_t;

    function automatic len_t stored_len(input len_t len, input logic pad);
        return len + (pad ? LEN_W'(PAD_BYTES) : LEN_W'(0));
    endfunction

    function automatic desc_t finish_word(input desc_t d, input len_t len, input logic pad);
        desc_t w;
        w = d;
        w[LEN_LSB +: LEN_W] = stored_len(len, pad);
        w[RDY_BIT] = 1'b0;
        return w;
    endfunction
endpackage

// File: rtl/rxc_complete.sv
module rxc_complete
    import rxc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_we,
    input  logic  cfg_crc_pad,
    input  logic  frame_done,
    input  len_t  frame_len,
    input  desc_t desc_in,
    output logic  rxb_set,
    output logic  desc_we,
    output desc_t desc_out
);
    logic pad_q;

    always_ff @(posedge clk) begin
        if (rst) pad_q <= 1'b1;
        else if (cfg_we) pad_q <= cfg_crc_pad;
    end

    assign rxb_set = frame_done & desc_in[RDY_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_we  <= 1'b0;
            desc_out <= '0;
        end else begin
            desc_we <= rxb_set;
            if (rxb_set) desc_out <= finish_word(desc_in, frame_len, pad_q);
        end
    end

    // R4
    wb_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && desc_in[RDY_BIT]) |=> (desc_we && !desc_out[RDY_BIT]));
    // R6
    wb_cause_chk: assert property (@(posedge clk) disable iff (rst)
        desc_we |-> ($past(frame_done) && $past(desc_in[RDY_BIT])));
endmodule

// File: rtl/rxc_drain.sv
module rxc_drain (
    input  logic clk,
    input  logic rst,
    input  logic frame_done,
    input  logic desc_ready,
    input  logic rx_pending,
    output logic drop_pop,
    output logic busy_set
);
    logic dropped_q;
    logic discard_now;

    assign drop_pop    = rx_pending & ~desc_ready;
    assign discard_now = drop_pop | (frame_done & ~desc_ready);
    assign busy_set    = dropped_q & ~rx_pending;

    always_ff @(posedge clk) begin
        if (rst) dropped_q <= 1'b0;
        else if (discard_now) dropped_q <= 1'b1;
        else if (!rx_pending) dropped_q <= 1'b0;
    end

    // R7
    drain_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(drop_pop) && !rx_pending) |-> busy_set);
endmodule

// File: rtl/rxc_irq.sv
module rxc_irq
    import rxc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] mask,
    output logic [N-1:0] src_q,
    output logic         line_q,
    output logic         event_q
);
    logic [N-1:0] src_next;
    logic         line_next;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign src_next[i] = set_vec[i] | (src_q[i] & ~clr_vec[i]);

        // R10
        set_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> src_q[i]);
    end

    assign line_next = |(src_next & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            line_q  <= 1'b0;
            event_q <= 1'b0;
        end else begin
            src_q   <= src_next;
            line_q  <= line_next;
            event_q <= line_next & ~line_q;
        end
    end

    // R8
    event_line_chk: assert property (@(posedge clk) disable iff (rst)
        event_q |-> line_q);
    // R9
    no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        event_q |-> !$past(line_q));
endmodule

// File: rtl/rx_desc_finish.sv
module rx_desc_finish
    import rxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_crc_pad,
    input  logic              frame_done,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [DESC_W-1:0] desc_in,
    input  logic              rx_pending,
    output logic              drop_pop,
    output logic              desc_we,
    output logic [DESC_W-1:0] desc_out,
    input  logic [NSRC-1:0]   src_clr,
    input  logic [NSRC-1:0]   irq_mask,
    output logic [NSRC-1:0]   int_src,
    output logic              irq_line,
    output logic              irq_event
);
    logic            rxb_set;
    logic            busy_set;
    logic [NSRC-1:0] set_vec;

    rxc_complete u_complete (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_crc_pad(cfg_crc_pad),
        .frame_done(frame_done), .frame_len(frame_len), .desc_in(desc_in),
        .rxb_set(rxb_set), .desc_we(desc_we), .desc_out(desc_out)
    );

    rxc_drain u_drain (
        .clk(clk), .rst(rst), .frame_done(frame_done),
        .desc_ready(desc_in[RDY_BIT]), .rx_pending(rx_pending),
        .drop_pop(drop_pop), .busy_set(busy_set)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[SRC_RXB]  = rxb_set;
        set_vec[SRC_BUSY] = busy_set;
    end

    rxc_irq #(.N(NSRC)) u_irq (
        .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(src_clr),
        .mask(irq_mask), .src_q(int_src), .line_q(irq_line), .event_q(irq_event)
    );
endmodule

// File: tb/sim_rx_desc_finish.sv
module sim_rx_desc_finish;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_crc_pad, frame_done, rx_pending;
    logic [15:0] frame_len;
    logic [31:0] desc_in;
    logic        drop_pop, desc_we, irq_line, irq_event;
    logic [31:0] desc_out;
    logic [1:0]  src_clr, irq_mask, int_src;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rx_desc_finish u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_crc_pad(cfg_crc_pad),
        .frame_done(frame_done), .frame_len(frame_len), .desc_in(desc_in),
        .rx_pending(rx_pending), .drop_pop(drop_pop), .desc_we(desc_we),
        .desc_out(desc_out), .src_clr(src_clr), .irq_mask(irq_mask),
        .int_src(int_src), .irq_line(irq_line), .irq_event(irq_event)
    );

    // completion vectors: pad setting, length, low descriptor bits, expected stored length
    localparam logic        V_PAD [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [15:0] V_LEN [4] = '{16'd60, 16'd1514, 16'hFFFE, 16'd0};
    localparam logic [14:0] V_LOW [4] = '{15'h6000, 15'h2001, 15'h7FFF, 15'h0000};
    localparam logic [15:0] V_EXP [4] = '{16'd64, 16'd1514, 16'h0002, 16'd0};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_we = 0; cfg_crc_pad = 0; frame_done = 0; rx_pending = 0;
        frame_len = 0; src_clr = 0;
    endtask

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        desc_in = 32'h0; irq_mask = 2'b00;
        rst = 1;
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        check("R1 int_src", {30'd0, int_src}, 0);
        check("R1 line", {31'd0, irq_line}, 0);
        check("R1 event", {31'd0, irq_event}, 0);
        check("R1 desc_we", {31'd0, desc_we}, 0);

        // R2 default padding without any configuration write
        frame_done = 1; frame_len = 16'd100; desc_in = 32'h0000_8005;
        step();
        idle();
        check("R2 default pad len", {16'd0, desc_out[31:16]}, 104);
        check("R4 we one cycle after", {31'd0, desc_we}, 1);
        check("R5 rxb set", {30'd0, int_src}, 2'b01);
        step();
        check("R4 we single cycle", {31'd0, desc_we}, 0);
        src_clr = 2'b01;
        step();
        idle();
        check("R10 clear rxb", {30'd0, int_src}, 0);

        // table walk: R2 R3 R4 R11
        for (int i = 0; i < 4; i++) begin
            cfg_we = 1; cfg_crc_pad = V_PAD[i];
            step();
            idle();
            frame_done = 1; frame_len = V_LEN[i]; desc_in = {16'hABCD, 1'b1, V_LOW[i]};
            step();
            idle();
            check("R3 R11 stored len", {16'd0, desc_out[31:16]}, {16'd0, V_EXP[i]});
            check("R4 ready cleared, low kept", {16'd0, desc_out[15:0]}, {16'd0, 1'b0, V_LOW[i]});
            check("R4 we", {31'd0, desc_we}, 1);
            src_clr = 2'b11;
            step();
            idle();
        end

        // R6 drain and R7 busy
        cfg_we = 1; cfg_crc_pad = 1;
        step();
        idle();
        irq_mask = 2'b10;
        desc_in = 32'h0000_0000;
        rx_pending = 1;
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R6 drop_pop while not ready", {31'd0, drop_pop}, 1);
            step();
            check("R7 busy not yet", {30'd0, int_src}, 0);
        end
        rx_pending = 0;
        #1;
        check("R6 drop stops when empty", {31'd0, drop_pop}, 0);
        step();
        check("R7 busy set", {30'd0, int_src}, 2'b10);
        check("R8 line up", {31'd0, irq_line}, 1);
        check("R8 event pulse", {31'd0, irq_event}, 1);
        step();
        check("R8 event single", {31'd0, irq_event}, 0);

        // R6 frame_done without ready descriptor is a discard; R9 no new event
        frame_done = 1; frame_len = 16'd200;
        step();
        idle();
        check("R6 no writeback", {31'd0, desc_we}, 0);
        step();
        check("R9 no event while active", {31'd0, irq_event}, 0);
        check("R9 line stays", {31'd0, irq_line}, 1);
        src_clr = 2'b10;
        step();
        idle();
        check("R10 busy cleared", {30'd0, int_src}, 0);
        check("R8 line drops", {31'd0, irq_line}, 0);

        // R10 set wins; R8 mask gating
        irq_mask = 2'b00;
        desc_in = 32'h0000_8000;
        frame_done = 1; frame_len = 16'd8; src_clr = 2'b01;
        step();
        idle();
        check("R10 set wins", {30'd0, int_src}, 2'b01);
        check("R8 masked no line", {31'd0, irq_line}, 0);
        irq_mask = 2'b01;
        step();
        check("R8 unmask raises line", {31'd0, irq_line}, 1);
        check("R8 unmask event", {31'd0, irq_event}, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule